// File: doc/BRIEF.md
# UTOPIA Receive Cell Port (PHY side, single PHY)

This block sits on the physical-layer side of a UTOPIA receive link and delivers buffered ATM cells to an ATM layer device. Cells arrive one 16-bit word per cycle through a plain write port (`wr_valid`, `wr_data`). They are stored in a FIFO that holds two whole cells. A cell is 54 bytes, so it is carried as 27 words. The ATM layer device clocks the link with `rx_clk` and requests words with the active-low `rx_enb_n`. The block answers with `rx_clav`, `rx_data` and the start-of-cell marker `rx_soc`. The write port shares `rx_clk`. Cell boundaries on the write side follow from counting words, 27 to a cell.

The `mode_octet` input chooses the handshake. Value 0 selects cell-level handshaking. In this mode `rx_clav` signals that at least one fully written cell is waiting, and a cell that has started is read to its end without further checks. Value 1 selects octet-level handshaking. In this mode `rx_clav` rises as soon as any word of an accepted cell is stored and unread, and it falls when the reader catches up with the writer. The transfer pauses mid-cell and resumes with the next word. The FIFO decides whether to accept a cell when its first word arrives. If both cell slots are taken at that moment, the entire cell is dropped.

The read side is a state machine with three states:
- `ST_IDLE`: waiting for the first word of a cell. It goes to `ST_XFER` when word 0 is taken.
- `ST_XFER`: mid-cell. It returns to `ST_IDLE` when the last word is taken. In octet mode it moves to `ST_PAUSE` when `rx_clav` is low and no word is taken.
- `ST_PAUSE`: octet mode only. It goes back to `ST_XFER` when `rx_clav` returns. It goes to `ST_IDLE` if the word taken on resume is the last word of the cell.

Top module: `utopia_rx_phy`

## Requirements
- R1: After synchronous active-low reset (`rst_n`=0), `rx_clav` is 0, `rx_data` is 0 and `rx_soc` is 0.
- R2: Each cell is delivered as exactly 27 words, and the words appear on `rx_data` in the order they were written.
- R3: `rx_soc` is 1 while the first word (W0) of a cell is on `rx_data`, and 0 for words W1 to W26.
- R4: A word is taken at a rising edge of `rx_clk` where `rx_enb_n` is 0 and a word is available. That word, with its `rx_soc`, is on the outputs from that edge onward.
- R5: While `rx_enb_n` is 1, `rx_data` and `rx_soc` keep their last values, and the word position holds. The next read continues with the following word.
- R6: With `mode_octet`=0, `rx_clav` stays 0 until all 27 words of a cell are written. It stays 1 throughout a cell transfer. It goes to 0 after the last word of the last buffered cell is taken.
- R7: With `mode_octet`=1, `rx_clav` is 1 whenever a word of an accepted cell is stored and unread. A low `rx_clav` with `rx_enb_n`=0 takes no word and holds `rx_data`. Once words are written again, the transfer continues from the next word.
- R8: The FIFO holds two complete cells. A cell whose first word arrives while two cells occupy the buffer is dropped whole: none of its words is ever presented, and later cells are unaffected.
- R9: `mode_octet` is held constant while the FIFO holds data. It may change only when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Link clock driven by the ATM layer device; also clocks the write port |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_octet | input | 1 | 0 = cell-level handshake, 1 = octet-level handshake |
| wr_valid | input | 1 | Write strobe; one cell word per cycle |
| wr_data | input | 16 | Cell word being written |
| rx_enb_n | input | 1 | Read enable from the ATM layer, active low |
| rx_clav | output | 1 | Cell / word available flag |
| rx_data | output | 16 | Delivered cell word |
| rx_soc | output | 1 | High with word W0 of each cell |

## Verification
The checker assumes several things about the inputs. It assumes `mode_octet` changes only while the FIFO is empty. It assumes that in cell mode the reader never pulls words beyond a committed cell. It assumes a rise of `rx_clav` can come only from a write in the previous cycle. Its own word counter advances on an enabled cycle with `rx_clav` high, and also on any enabled mid-cell cycle in cell mode. The stimulus keeps within these assumptions in three ways. It switches mode only after every cell has been drained. In cell mode it reads only whole cells that are already committed. In octet mode it reads exactly the words it has written before pausing.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_PAUSE
    } rd_state_e;
endpackage

// File: rtl/utopia_rx_store.sv
module utopia_rx_store #(
    parameter int WORD_W     = 16,
    parameter int CELL_WORDS = 27,
    parameter int CELLS      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_take,
    input  logic              rd_last,
    output logic [WORD_W-1:0] rd_word,
    output logic              avail_cell,
    output logic              avail_oct
);
    localparam int DEPTH = CELLS * CELL_WORDS;
    localparam int AW    = $clog2(DEPTH);
    localparam int IW    = $clog2(CELL_WORDS);
    localparam int CW    = $clog2(CELLS + 1);
    localparam int NW    = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [IW-1:0]     wr_idx;
    logic              wr_keep;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [NW-1:0]     cnt_written, cnt_commit;
    logic [CW-1:0]     held;

    logic wr_first, room, accept, wr_do, wr_end;

    // Cell acceptance is decided on word 0; a busy slot drops the whole cell
    assign wr_first = wr_valid && (wr_idx == '0);
    assign room     = held < CW'(CELLS);
    assign accept   = wr_first ? room : wr_keep;
    assign wr_do    = wr_valid && accept;
    assign wr_end   = wr_valid && (wr_idx == IW'(CELL_WORDS - 1));

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_do) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx      <= '0;
            wr_keep     <= 1'b0;
            wr_ptr      <= '0;
            rd_ptr      <= '0;
            cnt_written <= '0;
            cnt_commit  <= '0;
            held        <= '0;
        end else begin
            if (wr_end)        wr_idx <= '0;
            else if (wr_valid) wr_idx <= wr_idx + IW'(1);
            if (wr_first) wr_keep <= room;
            if (wr_do)    wr_ptr  <= ptr_inc(wr_ptr);
            if (rd_take)  rd_ptr  <= ptr_inc(rd_ptr);
            cnt_written <= cnt_written + NW'(wr_do) - NW'(rd_take);
            cnt_commit  <= cnt_commit + ((wr_do && wr_end) ? NW'(CELL_WORDS) : '0)
                           - NW'(rd_take);
            held        <= held + CW'(wr_do && wr_first) - CW'(rd_take && rd_last);
        end
    end

    assign rd_word    = mem[rd_ptr];
    assign avail_cell = cnt_commit != '0;
    assign avail_oct  = cnt_written != '0;
endmodule

// File: rtl/utopia_rx_ctrl.sv
module utopia_rx_ctrl
    import utopia_rx_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int CELL_WORDS = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_octet,
    input  logic              rx_enb_n,
    input  logic              avail_cell,
    input  logic              avail_oct,
    input  logic [WORD_W-1:0] rd_word,
    output logic              rx_clav,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_soc,
    output logic              rd_take,
    output logic              rd_last
);
    localparam int IW = $clog2(CELL_WORDS);

    rd_state_e     state, state_n;
    logic [IW-1:0] rd_idx;

    assign rx_clav = mode_octet ? avail_oct : avail_cell;
    assign rd_last = rd_idx == IW'(CELL_WORDS - 1);

    always_comb begin
        state_n = state;
        rd_take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                rd_take = !rx_enb_n && rx_clav;
                if (rd_take) state_n = ST_XFER;
            end
            ST_XFER: begin
                // cell mode: the started cell is complete, no recheck
                rd_take = !rx_enb_n && (rx_clav || !mode_octet);
                if (rd_take && rd_last)               state_n = ST_IDLE;
                else if (mode_octet && !rx_clav)      state_n = ST_PAUSE;
            end
            ST_PAUSE: begin
                rd_take = !rx_enb_n && rx_clav;
                if (rd_take && rd_last) state_n = ST_IDLE;
                else if (rx_clav)       state_n = ST_XFER;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_soc  <= 1'b0;
            rd_idx  <= '0;
        end else if (rd_take) begin
            rx_data <= rd_word;
            rx_soc  <= rd_idx == '0;
            rd_idx  <= rd_last ? '0 : rd_idx + IW'(1);
        end
    end
endmodule

// File: rtl/utopia_rx_phy.sv
module utopia_rx_phy #(
    parameter int WORD_W     = 16,
    parameter int CELL_WORDS = 27,
    parameter int CELLS      = 2
) (
    input  logic              rx_clk,
    input  logic              rst_n,
    input  logic              mode_octet,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rx_enb_n,
    output logic              rx_clav,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_soc
);
    logic [WORD_W-1:0] rd_word;
    logic avail_cell, avail_oct, rd_take, rd_last;

    utopia_rx_store #(.WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .CELLS(CELLS)) u_store (
        .clk(rx_clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_take(rd_take), .rd_last(rd_last), .rd_word(rd_word),
        .avail_cell(avail_cell), .avail_oct(avail_oct)
    );

    utopia_rx_ctrl #(.WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS)) u_ctrl (
        .clk(rx_clk), .rst_n(rst_n), .mode_octet(mode_octet), .rx_enb_n(rx_enb_n),
        .avail_cell(avail_cell), .avail_oct(avail_oct), .rd_word(rd_word),
        .rx_clav(rx_clav), .rx_data(rx_data), .rx_soc(rx_soc),
        .rd_take(rd_take), .rd_last(rd_last)
    );
endmodule

// File: rtl/utopia_rx_phy_chk.sv
module utopia_rx_phy_chk #(
    parameter int WORD_W     = 16,
    parameter int CELL_WORDS = 27
) (
    input logic              rx_clk,
    input logic              rst_n,
    input logic              mode_octet,
    input logic              wr_valid,
    input logic              rx_enb_n,
    input logic              rx_clav,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_soc
);
    localparam int IW = $clog2(CELL_WORDS);
    logic [IW-1:0] cnt;
    logic          xfer;

    assign xfer = !rx_enb_n && (rx_clav || (!mode_octet && cnt != '0));

    always_ff @(posedge rx_clk) begin
        if (!rst_n)    cnt <= '0;
        else if (xfer) cnt <= (cnt == IW'(CELL_WORDS - 1)) ? '0 : cnt + IW'(1);
    end

    // R3: marker only with the first word of each cell
    p_soc_first_r3: assert property (@(posedge rx_clk) disable iff (!rst_n)
        xfer |=> (rx_soc == $past(cnt == '0)));

    // R5: no transfer keeps the bus unchanged
    p_hold_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
        !xfer |=> ($stable(rx_data) && $stable(rx_soc)));

    // R6: cell-level flag stays high across a started cell
    p_cell_no_gap_r6: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (!mode_octet && cnt != '0) |-> rx_clav);

    // R7: availability only rises after a write
    p_clav_after_write_r7: assert property (@(posedge rx_clk) disable iff (!rst_n)
        $rose(rx_clav) |-> $past(wr_valid));
endmodule

bind utopia_rx_phy utopia_rx_phy_chk #(.WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS)) u_chk (
    .rx_clk(rx_clk), .rst_n(rst_n), .mode_octet(mode_octet), .wr_valid(wr_valid),
    .rx_enb_n(rx_enb_n), .rx_clav(rx_clav), .rx_data(rx_data), .rx_soc(rx_soc)
);

// File: tb/utopia_rx_phy_tb.sv
module utopia_rx_phy_tb_top;
    localparam int NW = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_octet = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rx_enb_n = 1'b1;
    logic        rx_clav;
    logic [15:0] rx_data;
    logic        rx_soc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    utopia_rx_phy dut_i (
        .rx_clk(clk), .rst_n(rst_n), .mode_octet(mode_octet), .wr_valid(wr_valid),
        .wr_data(wr_data), .rx_enb_n(rx_enb_n), .rx_clav(rx_clav),
        .rx_data(rx_data), .rx_soc(rx_soc)
    );

    // {mode_octet, base word}
    localparam logic [16:0] VEC [4] = '{
        {1'b0, 16'h1000}, {1'b1, 16'h2200}, {1'b0, 16'hA5F0}, {1'b1, 16'h7E00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_words(input logic [15:0] base, input int first, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = base + 16'(first + i);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic read_run(input string req, input logic [15:0] base, input int first, input int n);
        @(negedge clk);
        rx_enb_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk({req, " data"}, 32'(rx_data), 32'(base + 16'(first + k)));
            chk("R3 soc", 32'(rx_soc), 32'(first + k == 0));
        end
        rx_enb_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 clav", 32'(rx_clav), 0);
        chk("R1 data", 32'(rx_data), 0);
        chk("R1 soc", 32'(rx_soc), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R9: one cell per vector, mode changed only while empty
        for (int v = 0; v < 4; v++) begin
            mode_octet = VEC[v][16];
            write_words(VEC[v][15:0], 0, NW);
            chk("R6 clav full cell", 32'(rx_clav), 1);
            read_run("R2", VEC[v][15:0], 0, NW);
            chk("R6 clav after last", 32'(rx_clav), 0);
        end

        // R6: cell mode waits for the whole cell
        mode_octet = 1'b0;
        write_words(16'h3000, 0, NW - 1);
        chk("R6 clav partial", 32'(rx_clav), 0);
        write_words(16'h3000, NW - 1, 1);
        chk("R6 clav complete", 32'(rx_clav), 1);
        read_run("R4", 16'h3000, 0, NW);

        // R5: enable high mid-cell holds bus and position
        write_words(16'h4000, 0, NW);
        read_run("R5", 16'h4000, 0, 5);
        repeat (4) @(negedge clk);
        chk("R5 held data", 32'(rx_data), 32'h4004);
        chk("R5 held soc", 32'(rx_soc), 0);
        chk("R5 clav", 32'(rx_clav), 1);
        read_run("R5", 16'h4000, 5, NW - 5);

        // R7: octet mode pauses mid-cell and resumes
        mode_octet = 1'b1;
        write_words(16'h5000, 0, 3);
        chk("R7 clav early", 32'(rx_clav), 1);
        read_run("R7", 16'h5000, 0, 3);
        chk("R7 clav drained", 32'(rx_clav), 0);
        @(negedge clk);
        rx_enb_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 paused data", 32'(rx_data), 32'h5002);
        rx_enb_n = 1'b1;
        write_words(16'h5000, 3, NW - 3);
        read_run("R7", 16'h5000, 3, NW - 3);
        chk("R7 clav end", 32'(rx_clav), 0);

        // R8: third cell dropped while two are held
        mode_octet = 1'b0;
        write_words(16'h6000, 0, NW);
        write_words(16'h6100, 0, NW);
        write_words(16'h6200, 0, NW);
        read_run("R8", 16'h6000, 0, NW);
        chk("R8 second held", 32'(rx_clav), 1);
        read_run("R8", 16'h6100, 0, NW);
        chk("R8 dropped cell absent", 32'(rx_clav), 0);
        write_words(16'h6300, 0, NW);
        read_run("R8", 16'h6300, 0, NW);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule